// File: doc/BRIEF.md
# NAND Initial Bad Block Scanner

This block runs once at bring-up, before any write traffic reaches a NAND array. It walks every block except block 0, reads the factory bad-block marker byte from the spare area of the block's first page and, when needed, its second page, and records in a one-bit-per-block bitmap whether each block may be used. It never issues a program or erase command, because blocks the factory marked bad must not be touched.

The scanner does not drive the NAND pins itself. It hands a stream of micro-operations to a lower-level bus sequencer: command byte, address byte, wait for ready, and read one data byte. Each one is held until the sequencer acknowledges it. When the walk ends, the block raises a done flag and reports how many bad blocks it found. It also raises an error flag when that number is larger than a device in good health can show. The address mapping layer then queries the bitmap through a registered lookup port.

Top module: `nand_bb_scanner`

## Requirements
- R1: After a synchronous reset, done_o, err_o and uop_req_o are 0, bad_cnt_o is 0 and lk_bad_o is 1.
- R2: A one-cycle start_i pulse, while idle or done, starts a scan and clears done_o on the next clock edge.
- R3: Each page read is exactly nine micro-operations in this order, with op codes CMD=0, ADDR=1, WAIT=2, READ=3: CMD 00h; ADDR low and high byte of the marker column (2048 gives 00h then 08h); ADDR row bytes from least to most significant (three bytes, row = block × pages-per-block + page); CMD 30h; WAIT; READ.
- R4: A micro-operation stays requested with unchanged op and byte until uop_ack_i is seen. The next one is issued on the edge that takes the acknowledge.
- R5: Block 0 is never read and is always recorded as good.
- R6: Page 0 of each block is read first. If its marker is not FFh, the block is bad and page 1 of that block is not read.
- R7: If the page-0 marker is FFh, page 1 is read, and the block is bad exactly when that marker is not FFh.
- R8: The only command bytes ever issued are 00h and 30h.
- R9: After the last block is decided, done_o rises, uop_req_o stays 0, and bad_cnt_o equals the number of bad blocks.
- R10: err_o is 1 exactly when the bad-block count exceeds MAX_BAD (default 40).
- R11: lk_bad_o shows the bitmap bit for lk_blk_i one cycle after it is presented once done_o has been high for a cycle. In every cycle after one with done_o low, it is 1.
- R12: A start pulse after done_o begins a full rescan with the count and error cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse for a scan |
| uop_req_o | output | 1 | Micro-operation request |
| uop_op_o | output | 2 | Op code: 0 command, 1 address, 2 wait-ready, 3 read byte |
| uop_byte_o | output | 8 | Command or address byte |
| uop_ack_i | input | 1 | Sequencer acknowledge, one cycle |
| uop_rdata_i | input | 8 | Byte returned with the acknowledge of a read |
| lk_blk_i | input | clog2(NUM_BLOCKS) | Lookup block number |
| lk_bad_o | output | 1 | Block is bad, or map not yet valid |
| done_o | output | 1 | Scan finished |
| bad_cnt_o | output | clog2(NUM_BLOCKS+1) | Number of bad blocks found |
| err_o | output | 1 | Bad count above MAX_BAD |

## Verification
Every micro-operation is compared at the falling edge on which the bench's sequencer model accepts it. The model has 0 to 2 cycles of acknowledge latency, and it predicts the next operation from its own copy of the marker table. done_o, the count and the error flag change on the same edge that takes the last read acknowledge, so the bench samples them at the first falling edge after done_o is seen high. Lookup results are due one edge after the block number is driven and are checked on the following falling edge. The safe-while-scanning value is checked one full cycle after start, because the readiness flag lags done_o by one register.

// File: rtl/bbs_pkg.sv
package bbs_pkg;
  typedef enum logic [1:0] {
    UOP_CMD  = 2'd0,
    UOP_ADDR = 2'd1,
    UOP_WAIT = 2'd2,
    UOP_READ = 2'd3
  } uop_e;

  typedef struct packed {
    uop_e       op;
    logic [7:0] val;
  } uop_t;

  localparam logic [7:0] CMD_READ_SETUP = 8'h00;
  localparam logic [7:0] CMD_READ_GO    = 8'h30;
  localparam logic [7:0] ERASED_BYTE    = 8'hFF;
  localparam logic [3:0] LAST_STEP      = 4'd8;
endpackage

// File: rtl/bbs_bitmap.sv
module bbs_bitmap #(
  parameter int NUM_BLOCKS = 2048
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [$clog2(NUM_BLOCKS)-1:0] wr_addr,
  input  logic                          wr_bad,
  input  logic [$clog2(NUM_BLOCKS)-1:0] rd_addr,
  output logic                          rd_bad
);
  logic mem [NUM_BLOCKS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_bad;
    rd_bad <= mem[rd_addr];
  end
endmodule

// File: rtl/bbs_tally.sv
module bbs_tally #(
  parameter int NUM_BLOCKS = 2048,
  parameter int MAX_BAD    = 40
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            clr,
  input  logic                            inc,
  output logic [$clog2(NUM_BLOCKS+1)-1:0] cnt,
  output logic                            err
);
  localparam int CNT_W = $clog2(NUM_BLOCKS + 1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      err <= 1'b0;
    end else if (inc) begin
      cnt <= cnt + CNT_W'(1);
      err <= err | ((int'(cnt) + 1) > MAX_BAD);
    end
  end

  a_r9_cnt_monotonic: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt >= $past(cnt));
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err && !clr |=> err);
endmodule

// File: rtl/bbs_seq.sv
module bbs_seq
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MARK_COL        = 2048
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start_i,
  output logic                          req_o,
  output logic [1:0]                    op_o,
  output logic [7:0]                    val_o,
  input  logic                          ack_i,
  input  logic [7:0]                    rdata_i,
  output logic                          done_o,
  output logic                          wr_en_o,
  output logic [$clog2(NUM_BLOCKS)-1:0] wr_addr_o,
  output logic                          wr_bad_o,
  output logic                          bad_inc_o,
  output logic                          cnt_clr_o
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [7:0] COL_LO = 8'(MARK_COL);
  localparam logic [7:0] COL_HI = 8'(MARK_COL >> 8);

  typedef enum logic [1:0] {S_IDLE, S_INIT, S_ISSUE, S_DONE} st_e;

  st_e              st;
  logic [BLK_W-1:0] blk;
  logic             pg;
  logic [3:0]       step;
  uop_t             uop_q;
  logic             req_q;
  logic             done_q;

  function automatic logic [23:0] row_of(input logic [BLK_W-1:0] b, input logic p);
    return 24'(int'(b) * PAGES_PER_BLOCK + int'(p));
  endfunction

  function automatic uop_t build_uop(input logic [3:0] s, input logic [23:0] r);
    uop_t u;
    u.val = 8'h00;
    case (s)
      4'd0: begin u.op = UOP_CMD;  u.val = CMD_READ_SETUP; end
      4'd1: begin u.op = UOP_ADDR; u.val = COL_LO;         end
      4'd2: begin u.op = UOP_ADDR; u.val = COL_HI;         end
      4'd3: begin u.op = UOP_ADDR; u.val = r[7:0];         end
      4'd4: begin u.op = UOP_ADDR; u.val = r[15:8];        end
      4'd5: begin u.op = UOP_ADDR; u.val = r[23:16];       end
      4'd6: begin u.op = UOP_CMD;  u.val = CMD_READ_GO;    end
      4'd7: u.op = UOP_WAIT;
      default: u.op = UOP_READ;
    endcase
    return u;
  endfunction

  logic at_read, mark_bad, decide, idle_like;
  assign idle_like = (st == S_IDLE) || (st == S_DONE);
  assign at_read   = (st == S_ISSUE) && ack_i && (step == LAST_STEP);
  assign mark_bad  = (rdata_i != ERASED_BYTE);
  assign decide    = at_read && (mark_bad || pg);

  assign wr_en_o   = (st == S_INIT) || decide;
  assign wr_addr_o = (st == S_INIT) ? '0 : blk;
  assign wr_bad_o  = (st == S_INIT) ? 1'b0 : mark_bad;
  assign bad_inc_o = decide && mark_bad;
  assign cnt_clr_o = idle_like && start_i;

  assign req_o  = req_q;
  assign op_o   = uop_q.op;
  assign val_o  = uop_q.val;
  assign done_o = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      blk    <= '0;
      pg     <= 1'b0;
      step   <= '0;
      uop_q  <= '{op: UOP_CMD, val: 8'h00};
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE: begin
          if (start_i) begin
            st     <= S_INIT;
            done_q <= 1'b0;
          end
        end
        S_INIT: begin
          blk   <= BLK_W'(1);
          pg    <= 1'b0;
          step  <= '0;
          uop_q <= build_uop(4'd0, row_of(BLK_W'(1), 1'b0));
          req_q <= 1'b1;
          st    <= S_ISSUE;
        end
        S_ISSUE: begin
          if (ack_i) begin
            if (step != LAST_STEP) begin
              step  <= step + 4'd1;
              uop_q <= build_uop(step + 4'd1, row_of(blk, pg));
            end else if (!mark_bad && !pg) begin
              pg    <= 1'b1;
              step  <= '0;
              uop_q <= build_uop(4'd0, row_of(blk, 1'b1));
            end else if (blk == LAST_BLK) begin
              req_q  <= 1'b0;
              done_q <= 1'b1;
              st     <= S_DONE;
            end else begin
              blk   <= blk + BLK_W'(1);
              pg    <= 1'b0;
              step  <= '0;
              uop_q <= build_uop(4'd0, row_of(blk + BLK_W'(1), 1'b0));
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
    req_o && !ack_i |=> req_o && $stable(op_o) && $stable(val_o));
  a_r5_block0_good: assert property (@(posedge clk) disable iff (rst)
    wr_en_o && (wr_addr_o == '0) |-> !wr_bad_o);
  a_r8_read_cmds_only: assert property (@(posedge clk) disable iff (rst)
    req_o && (op_o == 2'd0) |-> (val_o == CMD_READ_SETUP) || (val_o == CMD_READ_GO));
  a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !req_o);
endmodule

// File: rtl/nand_bb_scanner.sv
module nand_bb_scanner #(
  parameter int NUM_BLOCKS      = 2048,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int MARK_COL        = 2048,
  parameter int MAX_BAD         = 40
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  output logic                              uop_req_o,
  output logic [1:0]                        uop_op_o,
  output logic [7:0]                        uop_byte_o,
  input  logic                              uop_ack_i,
  input  logic [7:0]                        uop_rdata_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0]     lk_blk_i,
  output logic                              lk_bad_o,
  output logic                              done_o,
  output logic [$clog2(NUM_BLOCKS+1)-1:0]   bad_cnt_o,
  output logic                              err_o
);
  localparam int BLK_W = $clog2(NUM_BLOCKS);

  logic             wr_en, wr_bad, bad_inc, cnt_clr;
  logic [BLK_W-1:0] wr_addr;
  logic             map_bit;
  logic             map_ready_q;

  bbs_seq #(
    .NUM_BLOCKS     (NUM_BLOCKS),
    .PAGES_PER_BLOCK(PAGES_PER_BLOCK),
    .MARK_COL       (MARK_COL)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .req_o    (uop_req_o),
    .op_o     (uop_op_o),
    .val_o    (uop_byte_o),
    .ack_i    (uop_ack_i),
    .rdata_i  (uop_rdata_i),
    .done_o   (done_o),
    .wr_en_o  (wr_en),
    .wr_addr_o(wr_addr),
    .wr_bad_o (wr_bad),
    .bad_inc_o(bad_inc),
    .cnt_clr_o(cnt_clr)
  );

  bbs_bitmap #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_bad (wr_bad),
    .rd_addr(lk_blk_i),
    .rd_bad (map_bit)
  );

  bbs_tally #(.NUM_BLOCKS(NUM_BLOCKS), .MAX_BAD(MAX_BAD)) u_tally (
    .clk(clk),
    .rst(rst),
    .clr(cnt_clr),
    .inc(bad_inc),
    .cnt(bad_cnt_o),
    .err(err_o)
  );

  always_ff @(posedge clk) begin
    if (rst) map_ready_q <= 1'b0;
    else     map_ready_q <= done_o;
  end

  assign lk_bad_o = map_bit | ~map_ready_q;

  a_r11_safe_during_scan: assert property (@(posedge clk) disable iff (rst)
    !done_o |=> lk_bad_o);
endmodule

// File: tb/nand_bb_scanner_tb.sv
module nand_bb_scanner_tb;
  localparam int NB   = 16;
  localparam int PG   = 4;
  localparam int MAXB = 3;
  localparam int COL  = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       req;
  logic [1:0] op;
  logic [7:0] val;
  logic       ack = 1'b0;
  logic [7:0] rdata = 8'h00;
  logic [3:0] lk_blk = '0;
  logic       lk_bad, done, err;
  logic [4:0] cnt;

  always #2 clk = ~clk;

  nand_bb_scanner #(.NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PG), .MARK_COL(COL), .MAX_BAD(MAXB)) u_dut (
    .clk(clk), .rst(rst), .start_i(start),
    .uop_req_o(req), .uop_op_o(op), .uop_byte_o(val),
    .uop_ack_i(ack), .uop_rdata_i(rdata),
    .lk_blk_i(lk_blk), .lk_bad_o(lk_bad),
    .done_o(done), .bad_cnt_o(cnt), .err_o(err)
  );

  int checks = 0;
  int fails  = 0;
  logic [7:0] mark [NB*2];
  int eblk = 1, epage = 0, estep = 0, lat = 0, wcnt = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit blk_bad(input int b);
    if (b == 0) return 1'b0;
    return (mark[2*b] != 8'hFF) || (mark[2*b+1] != 8'hFF);
  endfunction

  // Sequencer model: predicts each micro-op from the marker table.
  always @(negedge clk) begin
    if (ack) ack = 1'b0;
    else if (req) begin
      if (wcnt < lat) wcnt++;
      else begin
        int row, eop, ev;
        wcnt = 0;
        row = eblk * PG + epage;
        case (estep)
          0: begin eop = 0; ev = 8'h00; end
          1: begin eop = 1; ev = COL & 255; end
          2: begin eop = 1; ev = (COL >> 8) & 255; end
          3: begin eop = 1; ev = row & 255; end
          4: begin eop = 1; ev = (row >> 8) & 255; end
          5: begin eop = 1; ev = (row >> 16) & 255; end
          6: begin eop = 0; ev = 8'h30; end
          7: begin eop = 2; ev = -1; end
          default: begin eop = 3; ev = -1; end
        endcase
        if (eblk >= NB) chk(1'b0, "R9 micro-op after last block", eblk, NB);
        else chk((int'(op) == eop) && (ev < 0 || int'(val) == ev),
                 "R3 R4 R5 R6 R7 micro-op", {op, val}, (eop << 8) | (ev & 255));
        if (op == 2'd0) chk(val == 8'h00 || val == 8'h30, "R8 command byte", val, 8'h00);
        rdata = (estep == 8 && eblk < NB) ? mark[2*eblk+epage] : 8'h5A;
        ack = 1'b1;
        if (estep < 8) estep++;
        else begin
          if (eblk < NB && rdata == 8'hFF && epage == 0) epage = 1;
          else begin eblk++; epage = 0; end
          estep = 0;
        end
      end
    end
  end

  task automatic run_scan(input int latency, input string name);
    int ec;
    ec = 0;
    for (int b = 1; b < NB; b++) if (blk_bad(b)) ec++;
    lat = latency; eblk = 1; epage = 0; estep = 0; wcnt = 0;
    lk_blk = 4'd2;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done == 1'b0, "R2 R12 done cleared by start", done, 0);
    @(negedge clk);
    chk(lk_bad == 1'b1, "R11 lookup bad while scanning", lk_bad, 1);
    while (!done) @(negedge clk);
    chk(eblk == NB, "R9 all blocks visited", eblk, NB);
    chk(int'(cnt) == ec, "R9 R12 bad count", cnt, ec);
    chk(err == (ec > MAXB), "R10 error flag", err, ec > MAXB);
    chk(req == 1'b0, "R9 no request when done", req, 0);
    for (int b = 0; b < NB; b++) begin
      lk_blk = 4'(b);
      @(negedge clk);
      chk(lk_bad == blk_bad(b), "R11 R5 R6 R7 bitmap lookup", lk_bad, blk_bad(b));
    end
    $display("scan %s: %0d bad", name, ec);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB*2; i++) mark[i] = 8'hFF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 0 && req == 0 && err == 0, "R1 reset flags", {done, req, err}, 0);
    chk(cnt == 0, "R1 reset count", cnt, 0);
    chk(lk_bad == 1, "R1 reset lookup", lk_bad, 1);

    // Block 0 carries a marker that must be ignored (R5).
    mark[0] = 8'h00;
    run_scan(0, "all good");

    // Exactly MAXB bad: page 0, page 1, and the last block (R6, R7, R10 boundary).
    mark[2*3]    = 8'h00;
    mark[2*3+1]  = 8'h00;
    mark[2*5+1]  = 8'h7F;
    mark[2*15+1] = 8'h00;
    run_scan(1, "boundary");

    // Rescan with more bad blocks than allowed (R10, R12).
    mark[2*9]    = 8'hFE;
    mark[2*10+1] = 8'hEF;
    run_scan(2, "over limit");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule